// File: doc/BRIEF.md
# UART Interrupt Prioritizer and Identifier

This block gathers the four interrupt causes of a FIFO-based UART and reports the most urgent one. It presents an identification byte and one interrupt line. The causes are receive line errors, receive data (trigger level reached or character timeout), transmit holding empty, and modem line changes. Each cause passes through its own bit of a 4-bit enable mask.

The block holds two parts of the receive path itself. One compares the receive FIFO fill count against a level chosen by a 2-bit code. The other is a character-timeout counter. It runs on the 16x baud tick and scales its window from the current frame format. The surrounding UART supplies event pulses (line error, modem delta), FIFO push and pop strobes, the transmit-empty level, and register access strobes. Each latched cause is cleared by its own access strobe.

Top module: `uart_irq_id`

## Requirements
- R1: After reset the identification byte is C1h and irq_o is low. Bits 5:4 always read 0 and bits 7:6 always read 1.
- R2: Bit 0 of the identification byte is 0 when an enabled cause is pending and 1 otherwise. Bits 3:1 carry the cause code: line errors 011, data available 010, timeout 110, transmit empty 001, modem 000. Code 000 is also used when nothing is pending.
- R3: Level code 00/01/10/11 selects 1/4/8/14 bytes. Data available is pending while rx_count_i is at or above the level, and stops as soon as the count is below it.
- R4: The reported cause follows the priority order line errors, data available, timeout, transmit empty, modem. Data available is reported ahead of timeout when both are pending.
- R5: Enable bit 0 gates data available and timeout. Bit 1 gates transmit empty, bit 2 gates line errors and bit 3 gates modem. A disabled cause is never reported.
- R6: A line_err_i pulse latches the line-error cause, and a rd_lsr_i strobe clears it. When both arrive in the same cycle, the set wins.
- R7: A modem_delta_i pulse latches the modem cause, and a rd_msr_i strobe clears it. When both arrive in the same cycle, the set wins.
- R8: A 0-to-1 transition of tx_empty_i latches the transmit-empty cause. A wr_thr_i strobe clears it. tx_empty_i being high at reset does not latch the cause.
- R9: A rd_iir_i strobe clears the transmit-empty cause only in a cycle where that cause is the one being reported.
- R10: The timeout window is 64 x frame bits ticks of tick16_i, where frame bits = 1 start + (5 + data_bits_i) + parity_en_i + (two_stop_i ? 2 : 1). Timeout becomes pending on the tick that completes the window, provided rx_count_i was nonzero and there was no push or pop during the window.
- R11: A push or pop restarts the window. A pop, or an empty receive FIFO, clears a pending timeout.
- R12: irq_o is high exactly when any enabled cause is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ien_i | input | 4 | Cause enable mask |
| trig_code_i | input | 2 | Receive level code |
| rx_count_i | input | CNT_W | Receive FIFO fill count |
| rx_push_i | input | 1 | Receive FIFO write strobe |
| rx_pop_i | input | 1 | Receive buffer read strobe |
| line_err_i | input | 1 | Line error event pulse |
| modem_delta_i | input | 1 | Modem line change pulse |
| tx_empty_i | input | 1 | Transmit FIFO empty level |
| tick16_i | input | 1 | 16x baud tick |
| data_bits_i | input | 2 | Data length code (00 = 5 bits ... 11 = 8 bits) |
| parity_en_i | input | 1 | Parity bit present |
| two_stop_i | input | 1 | Two stop bits |
| rd_lsr_i | input | 1 | Line status read strobe |
| rd_msr_i | input | 1 | Modem status read strobe |
| rd_iir_i | input | 1 | Identification read strobe |
| wr_thr_i | input | 1 | Transmit data write strobe |
| iir_o | output | 8 | Identification byte |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong latched cause shows on iir_o and irq_o in the first cycle after the event or strobe that should have set or cleared it. The identification path is combinational from the latches. Level and priority faults show in the same cycle the inputs change. Timer faults show as a timeout one tick early or one tick late against the 64 x frame-bits window. The bench sweeps all level codes against every count and all sixteen frame formats, so an off-by-one at either boundary shows at the ports.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [2:0] {
    ID_MODEM = 3'b000,
    ID_THRE  = 3'b001,
    ID_RDA   = 3'b010,
    ID_LINE  = 3'b011,
    ID_TMO   = 3'b110
  } irq_id_e;

  localparam int unsigned MAX_FRAME_BITS = 12;
  localparam int unsigned TMO_CHARS      = 4;
  localparam int unsigned OVERSAMPLE     = 16;

  function automatic logic [3:0] frame_bits(input logic [1:0] db, input logic par,
                                            input logic two_stop);
    frame_bits = 4'd6 + {2'b00, db} + {3'b000, par} + (two_stop ? 4'd2 : 4'd1);
  endfunction
endpackage

// File: rtl/irq_rx_level.sv
module irq_rx_level #(
  parameter int unsigned CNT_W = 5
) (
  input  logic [1:0]       trig_code_i,
  input  logic [CNT_W-1:0] rx_count_i,
  output logic             rda_o
);
  logic [CNT_W-1:0] level;

  always_comb begin
    unique case (trig_code_i)
      2'b00:   level = CNT_W'(1);
      2'b01:   level = CNT_W'(4);
      2'b10:   level = CNT_W'(8);
      default: level = CNT_W'(14);
    endcase
  end

  assign rda_o = (rx_count_i >= level);
endmodule

// File: rtl/irq_char_timer.sv
module irq_char_timer
  import uart_irq_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic             rx_push_i,
  input  logic             rx_pop_i,
  input  logic             tick16_i,
  input  logic [1:0]       data_bits_i,
  input  logic             parity_en_i,
  input  logic             two_stop_i,
  output logic             tmo_o
);
  localparam int unsigned WIN_MAX = MAX_FRAME_BITS * OVERSAMPLE * TMO_CHARS;
  localparam int unsigned TW      = $clog2(WIN_MAX + 1);

  logic [TW-1:0] cnt_q, limit;
  logic          restart, empty, hit, tmo_q;

  assign limit   = TW'(frame_bits(data_bits_i, parity_en_i, two_stop_i)) *
                   TW'(OVERSAMPLE * TMO_CHARS);
  assign empty   = (rx_count_i == '0);
  assign restart = rx_push_i | rx_pop_i | empty;
  assign hit     = tick16_i & ~restart & (cnt_q >= limit - TW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (tick16_i && cnt_q < limit) cnt_q <= cnt_q + TW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tmo_q <= 1'b0;
    else if (rx_pop_i || empty) tmo_q <= 1'b0;
    else if (hit) tmo_q <= 1'b1;
  end

  assign tmo_o = tmo_q;

  // R11
  tmo_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_count_i == '0) |=> !tmo_q);
  // R11
  tmo_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_i |=> !tmo_q);
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    line_i,
  input  logic    rda_i,
  input  logic    tmo_i,
  input  logic    thre_i,
  input  logic    modem_i,
  output irq_id_e id_o,
  output logic    pend_o
);
  always_comb begin
    if (line_i)       id_o = ID_LINE;
    else if (rda_i)   id_o = ID_RDA;
    else if (tmo_i)   id_o = ID_TMO;
    else if (thre_i)  id_o = ID_THRE;
    else              id_o = ID_MODEM;
  end

  assign pend_o = line_i | rda_i | tmo_i | thre_i | modem_i;

  // R4
  line_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_i |-> (id_o == ID_LINE));
  // R4
  rda_over_tmo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rda_i && !line_i) |-> (id_o == ID_RDA));
endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
  import uart_irq_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       ien_i,
  input  logic [1:0]       trig_code_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic             rx_push_i,
  input  logic             rx_pop_i,
  input  logic             line_err_i,
  input  logic             modem_delta_i,
  input  logic             tx_empty_i,
  input  logic             tick16_i,
  input  logic [1:0]       data_bits_i,
  input  logic             parity_en_i,
  input  logic             two_stop_i,
  input  logic             rd_lsr_i,
  input  logic             rd_msr_i,
  input  logic             rd_iir_i,
  input  logic             wr_thr_i,
  output logic [7:0]       iir_o,
  output logic             irq_o
);
  logic    rda, tmo, line_q, modem_q, thre_q, tx_prev_q, tx_rise, pend;
  irq_id_e id;

  irq_rx_level #(.CNT_W(CNT_W)) u_level (
    .trig_code_i(trig_code_i), .rx_count_i(rx_count_i), .rda_o(rda));

  irq_char_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_count_i(rx_count_i),
    .rx_push_i(rx_push_i), .rx_pop_i(rx_pop_i), .tick16_i(tick16_i),
    .data_bits_i(data_bits_i), .parity_en_i(parity_en_i),
    .two_stop_i(two_stop_i), .tmo_o(tmo));

  assign tx_rise = tx_empty_i & ~tx_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q    <= 1'b0;
      modem_q   <= 1'b0;
      thre_q    <= 1'b0;
      tx_prev_q <= 1'b1;
    end else begin
      tx_prev_q <= tx_empty_i;
      if (line_err_i) line_q <= 1'b1;
      else if (rd_lsr_i) line_q <= 1'b0;
      if (modem_delta_i) modem_q <= 1'b1;
      else if (rd_msr_i) modem_q <= 1'b0;
      if (tx_rise) thre_q <= 1'b1;
      else if (wr_thr_i || (rd_iir_i && pend && id == ID_THRE)) thre_q <= 1'b0;
    end
  end

  irq_prio_enc u_enc (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .line_i(line_q & ien_i[2]), .rda_i(rda & ien_i[0]), .tmo_i(tmo & ien_i[0]),
    .thre_i(thre_q & ien_i[1]), .modem_i(modem_q & ien_i[3]),
    .id_o(id), .pend_o(pend));

  assign iir_o = {2'b11, 2'b00, id, ~pend};
  assign irq_o = pend;

  // R6
  line_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_lsr_i && !line_err_i) |=> !line_q);
  // R7
  modem_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_msr_i && !modem_delta_i) |=> !modem_q);
  // R8
  thre_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_thr_i && !tx_rise) |=> !thre_q);
  // R9
  thre_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thre_q && rd_iir_i && !wr_thr_i && iir_o[3:1] != 3'b001) |=> thre_q);
endmodule

// File: tb/uart_irq_id_test.sv
`timescale 1ns/1ps
module uart_irq_id_test;
  localparam int CNT_W = 5;
  logic clk = 0, rst_ni = 0;
  logic [3:0] ien = 0;
  logic [1:0] trig = 0, db = 2'b11;
  logic [CNT_W-1:0] cnt = 0;
  logic push = 0, pop = 0, lerr = 0, mdel = 0, txe = 1, tick = 0;
  logic par = 0, two = 0, rlsr = 0, rmsr = 0, riir = 0, wthr = 0;
  logic [7:0] iir;
  logic irq;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  uart_irq_id #(.CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .ien_i(ien), .trig_code_i(trig),
    .rx_count_i(cnt), .rx_push_i(push), .rx_pop_i(pop), .line_err_i(lerr),
    .modem_delta_i(mdel), .tx_empty_i(txe), .tick16_i(tick),
    .data_bits_i(db), .parity_en_i(par), .two_stop_i(two),
    .rd_lsr_i(rlsr), .rd_msr_i(rmsr), .rd_iir_i(riir), .wr_thr_i(wthr),
    .iir_o(iir), .irq_o(irq));

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input logic [7:0] exp, input string tag);
    #1;
    checks++;
    if (iir !== exp || irq !== ~exp[0]) begin
      errors++;
      $display("FAIL %s: iir=%h irq=%b expected iir=%h irq=%b", tag, iir, irq, exp, ~exp[0]);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(); step();
    chk(8'hC1, "R1 in reset");
    rst_ni = 1; step();
    ien = 4'hF;
    chk(8'hC1, "R1 after reset, R8 tx empty at reset not latched");

    // R3 level sweep, R2 encoding
    ien = 4'b0001;
    for (int c = 0; c < 4; c++) begin
      for (int n = 0; n <= 16; n++) begin
        int lvl;
        lvl = (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 14;
        trig = c[1:0]; cnt = n[CNT_W-1:0]; push = 1;
        chk((n >= lvl) ? 8'hC4 : 8'hC1, "R3 level compare");
      end
    end
    push = 0; cnt = 0; step();

    // R5 mask
    trig = 0; cnt = 3; ien = 4'b1110;
    chk(8'hC1, "R5 rda masked");
    ien = 4'b0001; chk(8'hC4, "R5 rda enabled");

    // R6 line errors and priority
    ien = 4'b0101;
    lerr = 1; step(); lerr = 0;
    chk(8'hC6, "R6 R4 line over rda");
    ien = 4'b0001; chk(8'hC4, "R5 line masked");
    ien = 4'b0101;
    lerr = 1; rlsr = 1; step(); lerr = 0; rlsr = 0;
    chk(8'hC6, "R6 set wins over clear");
    rlsr = 1; step(); rlsr = 0;
    chk(8'hC4, "R6 cleared by lsr read");
    cnt = 0; step();

    // R7 modem
    ien = 4'b1000;
    mdel = 1; step(); mdel = 0;
    chk(8'hC0, "R7 modem pending");
    ien = 4'b0000; chk(8'hC1, "R12 nothing enabled");
    ien = 4'b1000;
    rmsr = 1; step(); rmsr = 0;
    chk(8'hC1, "R7 cleared by msr read");

    // R8 transmit empty
    ien = 4'b1010;
    mdel = 1; step(); mdel = 0;
    txe = 0; step(); txe = 1; step();
    chk(8'hC2, "R8 R4 thre over modem");
    wthr = 1; step(); wthr = 0;
    chk(8'hC0, "R8 cleared by write");
    txe = 0; step(); txe = 1; step();
    chk(8'hC2, "R8 set again on rise");
    riir = 1; step(); riir = 0;
    chk(8'hC0, "R9 cleared by iir read when reported");
    rmsr = 1; step(); rmsr = 0;

    // R9 iir read while line reported keeps thre
    ien = 4'b0110;
    txe = 0; step(); txe = 1; lerr = 1; step(); lerr = 0;
    chk(8'hC6, "R9 line reported");
    riir = 1; step(); riir = 0;
    rlsr = 1; step(); rlsr = 0;
    chk(8'hC2, "R9 thre kept after iir read");
    wthr = 1; step(); wthr = 0;

    // R10 timeout window per format
    ien = 4'b0001; trig = 2'b11;
    for (int f = 0; f < 16; f++) begin
      int lim;
      db = f[1:0]; par = f[2]; two = f[3];
      lim = 64 * (1 + 5 + f[1:0] + f[2] + (f[3] ? 2 : 1));
      cnt = 1; push = 1; tick = 1; step(); push = 0;
      repeat (lim - 1) step();
      chk(8'hC1, "R10 no timeout one tick early");
      step();
      chk(8'hCC, "R10 timeout at window end");
      pop = 1; step(); pop = 0;
      chk(8'hC1, "R11 pop clears timeout");
    end

    // R11 push restarts
    db = 2'b11; par = 0; two = 0;
    cnt = 1; push = 1; step(); push = 0;
    repeat (300) step();
    push = 1; step(); push = 0;
    repeat (639) step();
    chk(8'hC1, "R11 push restarted window");
    step();
    chk(8'hCC, "R11 timeout after restart");
    cnt = 14; chk(8'hC4, "R4 rda ahead of timeout");
    cnt = 0; step(); cnt = 1;
    chk(8'hC1, "R11 empty fifo cleared timeout");
    tick = 0; cnt = 0; step();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule